// File: doc/BRIEF.md
# LCD controller register bank

This block is the control register file of a dot-clock display controller. A 32-bit register bus writes and reads five registers. They hold the control word, a secondary control word, the transfer count, the frame-buffer address the scan-out engine is using now, and the frame-buffer address it will use next. Each register sits in its own 16-byte block. An access to block offset 0 replaces the writable bits. Offset 4 ORs the written bits in, and offset 8 clears the written bits. Software can therefore change single control bits without a read-modify-write.

The bank also carries three pieces of hardware behaviour that software relies on. A new frame-buffer address is held until the rising edge of vsync and only then becomes the current address, so a page flip never tears mid-frame. When software drops dotclock mode, the run bit stays set and clears itself only once the pixel FIFO reports empty. A soft-reset bit and a FIFO-clear bit act as self-clearing strobes.

Top module: `lcd_reg_bank`

## Requirements
- R1: After the asynchronous reset every register reads zero, and every register output and `rdata_o` are zero.
- R2: A write to a block base (control 0x00, secondary control 0x10, transfer count 0x20, current buffer 0x30, next buffer 0x40) replaces the writable bits. Control writable bits are 31 (soft reset), 30 (clock gate), 17 (dotclock mode), 11:10 (output bus width code), 9:8 (input word length), 5 (bus master) and 0 (run). Secondary control writable bits are 21 (FIFO clear) and 19:16 (byte-packing mask). All other bits of these two registers read zero.
- R3: A write to base+4 ORs the writable written bits into the register. A write to base+8 clears them. No other bit changes.
- R4: A read at base+4 or base+8 returns the base register value. Reads at offset 0xC of any block, and reads of blocks 0x50 and above, return zero. Writes there change no register.
- R5: `rdata_o` is loaded on the clock edge that samples `re_i` high and then holds. A read in the same cycle as a write to the same register returns the value from before the write.
- R6: The transfer count register is fully writable and appears on `xfer_cnt_o`: active lines in bits 31:16 and pixels per line in bits 15:0.
- R7: A write to the next-buffer register leaves `cur_buf_o` unchanged. On the clock edge that first samples `vsync_i` high after it was low, `cur_buf_o` takes the next-buffer value held before that edge. A held-high `vsync_i` loads nothing more.
- R8: The current-buffer register ignores all bus writes, including writes to its aliases.
- R9: On an edge where run (bit 0) is 1, dotclock mode (bit 17) is 0 and `fifo_empty_i` is 1, run clears. While the FIFO is not empty, or while dotclock mode is set, run stays set.
- R10: FIFO clear (secondary control bit 21) stays set for exactly one cycle and appears on `fifo_clr_o`. The byte-packing bits are not affected.
- R11: One cycle after soft reset (control bit 31) is set, every register becomes zero except control bit 30, which keeps its value. Bit 31 clears as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| vsync_i | input | 1 | Vertical sync from the timing generator |
| fifo_empty_i | input | 1 | Pixel FIFO empty flag |
| ctrl_o | output | 32 | Control word |
| ctrl1_o | output | 32 | Secondary control word |
| xfer_cnt_o | output | 32 | Transfer count |
| cur_buf_o | output | 32 | Frame-buffer address in use |
| next_buf_o | output | 32 | Frame-buffer address queued for the next frame |
| fifo_clr_o | output | 1 | FIFO clear strobe |

## Verification
The hardest cases to reach are the ones where hardware and the bus act on the same edge. One is a next-buffer write landing on the vsync edge. The other is run being held across a drain that has not finished. The stimulus aligns the write strobe and the vsync rise in one cycle and checks that the old queued address is swapped in. It keeps `fifo_empty_i` low for several cycles after dotclock mode is cleared, then raises it and expects run to fall on that one edge. Walking-one sweeps over every writable register and a sweep over every unmapped address complete the map checks.

// File: rtl/lcd_reg_pkg.sv
package lcd_reg_pkg;
  localparam int unsigned DW         = 32;
  localparam int unsigned N_REGS     = 5;
  localparam int unsigned STRIDE_LSB = 4;

  localparam int unsigned I_CTRL  = 0;
  localparam int unsigned I_CTRL1 = 1;
  localparam int unsigned I_XFER  = 2;
  localparam int unsigned I_CUR   = 3;
  localparam int unsigned I_NEXT  = 4;

  localparam int unsigned B_SRST    = 31;
  localparam int unsigned B_CLKGATE = 30;
  localparam int unsigned B_DOTCLK  = 17;
  localparam int unsigned B_RUN     = 0;
  localparam int unsigned B_FIFOCLR = 21;

  localparam logic [DW-1:0] CTRL_WMASK  = 32'hC002_0F21;
  localparam logic [DW-1:0] CTRL1_WMASK = 32'h002F_0000;
  localparam logic [DW-1:0] CTRL_KEEP   = 32'h4000_0000;

  typedef enum logic [1:0] {
    OP_WR   = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } reg_op_e;

  function automatic logic [DW-1:0] wmask_of(int unsigned idx);
    case (idx)
      I_CTRL:  return CTRL_WMASK;
      I_CTRL1: return CTRL1_WMASK;
      I_CUR:   return '0;
      default: return '1;
    endcase
  endfunction

  function automatic logic [DW-1:0] keep_of(int unsigned idx);
    return (idx == I_CTRL) ? CTRL_KEEP : '0;
  endfunction
endpackage

// File: rtl/lcd_addr_dec.sv
module lcd_addr_dec
  import lcd_reg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N      = N_REGS,
  localparam int unsigned BLK_W = ADDR_W - STRIDE_LSB
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic [N-1:0]      wsel_o,
  output reg_op_e           op_o,
  output logic              hit_o,
  output logic [BLK_W-1:0]  blk_o
);
  logic [1:0] sub;

  assign blk_o = addr_i[ADDR_W-1:STRIDE_LSB];
  assign sub   = addr_i[STRIDE_LSB-1:2];
  // offset 0xC of each block is a hole
  assign hit_o = (32'(blk_o) < N) && (sub != 2'd3);
  assign op_o  = hit_o ? reg_op_e'(sub) : OP_NONE;

  for (genvar i = 0; i < N; i++) begin : g_sel
    assign wsel_o[i] = we_i && hit_o && (32'(blk_o) == i);
  end
endmodule

// File: rtl/lcd_alias_reg.sv
module lcd_alias_reg
  import lcd_reg_pkg::*;
#(
  parameter int unsigned    W     = DW,
  parameter logic [W-1:0]   WMASK = '1,
  parameter logic [W-1:0]   KEEP  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic         sel_i,
  input  reg_op_e      op_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_clr_i,
  input  logic         hw_ld_i,
  input  logic [W-1:0] hw_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] base, wbits, nxt;

  always_comb begin
    // hardware update first, bus write layered on top
    base  = hw_ld_i ? hw_val_i : (q_o & ~hw_clr_i);
    wbits = wdata_i & WMASK;
    nxt   = base;
    if (sel_i) begin
      case (op_i)
        OP_WR:   nxt = (base & ~WMASK) | wbits;
        OP_SET:  nxt = base | wbits;
        OP_CLR:  nxt = base & ~wbits;
        default: nxt = base;
      endcase
    end
    if (srst_i) nxt = q_o & KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt;
  end
endmodule

// File: rtl/lcd_reg_bank.sv
module lcd_reg_bank
  import lcd_reg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [31:0]       rdata_o,
  input  logic              vsync_i,
  input  logic              fifo_empty_i,
  output logic [31:0]       ctrl_o,
  output logic [31:0]       ctrl1_o,
  output logic [31:0]       xfer_cnt_o,
  output logic [31:0]       cur_buf_o,
  output logic [31:0]       next_buf_o,
  output logic              fifo_clr_o
);
  localparam int unsigned BLK_W = ADDR_W - STRIDE_LSB;

  logic [N_REGS-1:0] wsel;
  reg_op_e           op;
  logic              hit;
  logic [BLK_W-1:0]  blk;

  logic [DW-1:0]     q      [N_REGS];
  logic [DW-1:0]     hw_clr [N_REGS];
  logic [DW-1:0]     hw_val [N_REGS];
  logic [N_REGS-1:0] hw_ld;
  logic [DW-1:0]     rd_mux;

  logic vs_q, vs_rise, srst, drain_done;

  lcd_addr_dec #(.ADDR_W(ADDR_W), .N(N_REGS)) u_dec (
    .addr_i (addr_i),
    .we_i   (we_i),
    .wsel_o (wsel),
    .op_o   (op),
    .hit_o  (hit),
    .blk_o  (blk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vs_q <= 1'b0;
    else         vs_q <= vsync_i;
  end

  assign vs_rise    = vsync_i & ~vs_q;
  assign srst       = q[I_CTRL][B_SRST];
  // run drops once the FIFO has drained after dotclock mode is off
  assign drain_done = q[I_CTRL][B_RUN] & ~q[I_CTRL][B_DOTCLK] & fifo_empty_i;

  always_comb begin
    for (int i = 0; i < N_REGS; i++) begin
      hw_clr[i] = '0;
      hw_val[i] = '0;
    end
    hw_ld                     = '0;
    hw_clr[I_CTRL][B_RUN]     = drain_done;
    hw_clr[I_CTRL1][B_FIFOCLR] = q[I_CTRL1][B_FIFOCLR];
    hw_ld[I_CUR]              = vs_rise;
    hw_val[I_CUR]             = q[I_NEXT];
  end

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    lcd_alias_reg #(
      .W     (DW),
      .WMASK (wmask_of(i)),
      .KEEP  (keep_of(i))
    ) u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .srst_i   (srst),
      .sel_i    (wsel[i]),
      .op_i     (op),
      .wdata_i  (wdata_i),
      .hw_clr_i (hw_clr[i]),
      .hw_ld_i  (hw_ld[i]),
      .hw_val_i (hw_val[i]),
      .q_o      (q[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      for (int i = 0; i < N_REGS; i++) begin
        if (32'(blk) == i) rd_mux = q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end

  assign ctrl_o     = q[I_CTRL];
  assign ctrl1_o    = q[I_CTRL1];
  assign xfer_cnt_o = q[I_XFER];
  assign cur_buf_o  = q[I_CUR];
  assign next_buf_o = q[I_NEXT];
  assign fifo_clr_o = q[I_CTRL1][B_FIFOCLR];
endmodule

// File: rtl/lcd_reg_bank_chk.sv
module lcd_reg_bank_chk
  import lcd_reg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              we_i,
  input logic              re_i,
  input logic [31:0]       rdata_o,
  input logic              vsync_i,
  input logic              fifo_empty_i,
  input logic [31:0]       ctrl_o,
  input logic [31:0]       ctrl1_o,
  input logic [31:0]       xfer_cnt_o,
  input logic [31:0]       cur_buf_o,
  input logic [31:0]       next_buf_o,
  input logic              fifo_clr_o
);
  logic vs_seen, rd_unm_q, unmapped;

  assign unmapped = (addr_i[STRIDE_LSB-1:2] == 2'd3) ||
                    (32'(addr_i[ADDR_W-1:STRIDE_LSB]) >= N_REGS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_seen  <= 1'b0;
      rd_unm_q <= 1'b0;
    end else begin
      vs_seen  <= vsync_i;
      rd_unm_q <= re_i && unmapped;
    end
  end

  p_rd_unmapped_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_unm_q |-> rdata_o == 32'h0);

  p_set_alias_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == ADDR_W'('h44) && !ctrl_o[31]
    |=> next_buf_o == ($past(next_buf_o) | $past(wdata_i)));

  p_cur_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vsync_i && !vs_seen) && !ctrl_o[31] |=> $stable(cur_buf_o));

  p_cur_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_i && !vs_seen && !ctrl_o[31] |=> cur_buf_o == $past(next_buf_o));

  p_run_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[0] && !ctrl_o[17] && fifo_empty_i && !we_i |=> !ctrl_o[0]);

  p_run_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[0] && (!fifo_empty_i || ctrl_o[17]) && !we_i && !ctrl_o[31] |=> ctrl_o[0]);

  p_fifo_clr_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_o && !we_i |=> !fifo_clr_o);

  p_srst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[31] |=> ctrl_o == ($past(ctrl_o) & 32'h4000_0000) && ctrl1_o == 32'h0 &&
                   xfer_cnt_o == 32'h0 && cur_buf_o == 32'h0 && next_buf_o == 32'h0);
endmodule

bind lcd_reg_bank lcd_reg_bank_chk #(.ADDR_W(ADDR_W)) i_lcd_reg_bank_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .we_i         (we_i),
  .re_i         (re_i),
  .rdata_o      (rdata_o),
  .vsync_i      (vsync_i),
  .fifo_empty_i (fifo_empty_i),
  .ctrl_o       (ctrl_o),
  .ctrl1_o      (ctrl1_o),
  .xfer_cnt_o   (xfer_cnt_o),
  .cur_buf_o    (cur_buf_o),
  .next_buf_o   (next_buf_o),
  .fifo_clr_o   (fifo_clr_o)
);

// File: tb/test_lcd_reg_bank.sv
module test_lcd_reg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic        vsync = 1'b0;
  logic        fifo_empty = 1'b0;
  logic [31:0] ctrl, ctrl1, xfer, cur, nxt;
  logic        fifo_clr;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lcd_reg_bank #(.ADDR_W(8)) i_lcd_reg_bank (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .addr_i       (addr),
    .wdata_i      (wdata),
    .we_i         (we),
    .re_i         (re),
    .rdata_o      (rdata),
    .vsync_i      (vsync),
    .fifo_empty_i (fifo_empty),
    .ctrl_o       (ctrl),
    .ctrl1_o      (ctrl1),
    .xfer_cnt_o   (xfer),
    .cur_buf_o    (cur),
    .next_buf_o   (nxt),
    .fifo_clr_o   (fifo_clr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  initial begin
    logic [31:0] r;
    logic [7:0]  regs [4];
    logic [31:0] msk  [4];
    logic [31:0] skip [4];
    regs = '{8'h00, 8'h10, 8'h20, 8'h40};
    msk  = '{32'h4002_0F21, 32'h000F_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
    skip = '{32'h8000_0000, 32'h0020_0000, 32'h0, 32'h0};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 5; i++) begin
      rd(8'(i * 16), r);
      chk("R1", "reset read", r, 32'h0);
    end
    chk("R1", "ctrl_o", ctrl, 32'h0);
    chk("R1", "cur_buf_o", cur, 32'h0);
    chk("R1", "fifo_clr_o", {31'h0, fifo_clr}, 32'h0);

    // R2 walking ones and all-ones over writable registers
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 32; b++) begin
        logic [31:0] v;
        v = 32'h1 << b;
        if ((v & skip[k]) != 0) continue;
        wr(regs[k], v);
        rd(regs[k], r);
        chk("R2", "walking one", r, v & msk[k]);
      end
      wr(regs[k], ~skip[k]);
      rd(regs[k], r);
      chk("R2", "all ones", r, msk[k]);
      wr(regs[k], 32'h0);
    end

    // R3 / R4 alias writes and alias reads
    for (int k = 2; k < 4; k++) begin
      wr(regs[k], 32'h0000_FF00);
      wr(regs[k] + 8'h4, 32'h00F0_000F);
      rd(regs[k] + 8'h4, r);
      chk("R3", "set alias", r, 32'h00F0_FF0F);
      wr(regs[k] + 8'h8, 32'h0000_0F0F);
      rd(regs[k] + 8'h8, r);
      chk("R3", "clear alias", r, 32'h00F0_F000);
      rd(regs[k], r);
      chk("R4", "base after aliases", r, 32'h00F0_F000);
    end
    wr(8'h10, 32'h0003_0000);
    wr(8'h14, 32'h0008_0000);
    chk("R3", "ctrl1 set", ctrl1, 32'h000B_0000);
    wr(8'h18, 32'h0001_0000);
    chk("R3", "ctrl1 clear", ctrl1, 32'h000A_0000);
    wr(8'h00, 32'h0002_0001);
    wr(8'h04, 32'h0000_0C00);
    chk("R3", "ctrl set", ctrl, 32'h0002_0C01);
    wr(8'h08, 32'h0000_0001);
    chk("R3", "ctrl clear", ctrl, 32'h0002_0C00);
    wr(8'h00, 32'h0);
    wr(8'h10, 32'h0);

    // R4 holes and unmapped blocks
    wr(8'h40, 32'hCAFE_F00D);
    wr(8'h20, 32'h1234_5678);
    for (int a = 8'h0C; a < 8'h50; a += 16) begin
      wr(8'(a), 32'hFFFF_FFFF);
      rd(8'(a), r);
      chk("R4", "hole read", r, 32'h0);
    end
    for (int a = 8'h50; a < 256; a += 4) begin
      wr(8'(a), 32'hFFFF_FFFF);
      rd(8'(a), r);
      chk("R4", "unmapped read", r, 32'h0);
    end
    chk("R4", "ctrl untouched", ctrl, 32'h0);
    chk("R4", "ctrl1 untouched", ctrl1, 32'h0);
    chk("R4", "xfer untouched", xfer, 32'h1234_5678);
    chk("R4", "next untouched", nxt, 32'hCAFE_F00D);
    chk("R4", "cur untouched", cur, 32'h0);

    // R5 read concurrent with write returns old value, then holds
    @(negedge clk);
    addr = 8'h40; wdata = 32'h2222_2222; we = 1'b1; re = 1'b1;
    @(negedge clk);
    we = 1'b0; re = 1'b0;
    chk("R5", "read during write", rdata, 32'hCAFE_F00D);
    repeat (2) @(negedge clk);
    chk("R5", "rdata holds", rdata, 32'hCAFE_F00D);
    chk("R5", "write landed", nxt, 32'h2222_2222);

    // R6 transfer count fields
    wr(8'h20, {16'd480, 16'd640});
    chk("R6", "lines field", {16'h0, xfer[31:16]}, 32'd480);
    chk("R6", "pixels field", {16'h0, xfer[15:0]}, 32'd640);

    // R7 double-buffered frame address
    wr(8'h40, 32'h1000_0000);
    repeat (3) @(negedge clk);
    chk("R7", "no swap without vsync", cur, 32'h0);
    vsync = 1'b1;
    @(negedge clk);
    chk("R7", "swap on vsync rise", cur, 32'h1000_0000);
    wr(8'h40, 32'h2000_0000);
    repeat (3) @(negedge clk);
    chk("R7", "held vsync no reload", cur, 32'h1000_0000);
    vsync = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7", "vsync fall no load", cur, 32'h1000_0000);
    vsync = 1'b1;
    @(negedge clk);
    chk("R7", "second swap", cur, 32'h2000_0000);
    vsync = 1'b0;
    wr(8'h40, 32'h3000_0000);
    @(negedge clk);
    addr = 8'h40; wdata = 32'h4000_0000; we = 1'b1; vsync = 1'b1;
    @(negedge clk);
    we = 1'b0;
    chk("R7", "same-edge write: cur old next", cur, 32'h3000_0000);
    chk("R7", "same-edge write: next new", nxt, 32'h4000_0000);
    vsync = 1'b0;

    // R8 current buffer is read-only
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h30, r);
    chk("R8", "cur ignores writes", r, 32'h3000_0000);

    // R9 graceful stop
    wr(8'h00, 32'h0002_0001);
    wr(8'h08, 32'h0002_0000);
    repeat (4) @(negedge clk);
    chk("R9", "run held while FIFO busy", ctrl, 32'h0000_0001);
    fifo_empty = 1'b1;
    @(negedge clk);
    chk("R9", "run cleared on drain", ctrl, 32'h0);
    wr(8'h00, 32'h0002_0001);
    repeat (4) @(negedge clk);
    chk("R9", "run held in dotclock mode", ctrl, 32'h0002_0001);
    fifo_empty = 1'b0;
    wr(8'h00, 32'h0);

    // R10 FIFO clear strobe
    wr(8'h10, 32'h0005_0000);
    wr(8'h14, 32'h0020_0000);
    chk("R10", "fifo_clr high", {31'h0, fifo_clr}, 32'h1);
    chk("R10", "ctrl1 with strobe", ctrl1, 32'h0025_0000);
    @(negedge clk);
    chk("R10", "fifo_clr low", {31'h0, fifo_clr}, 32'h0);
    chk("R10", "packing kept", ctrl1, 32'h0005_0000);

    // R11 soft reset keeps clock gate only
    wr(8'h00, 32'h4000_0F20);
    wr(8'h04, 32'h8000_0000);
    chk("R11", "srst latched", ctrl, 32'hC000_0F20);
    @(negedge clk);
    chk("R11", "ctrl after srst", ctrl, 32'h4000_0000);
    chk("R11", "ctrl1 after srst", ctrl1, 32'h0);
    chk("R11", "xfer after srst", xfer, 32'h0);
    chk("R11", "cur after srst", cur, 32'h0);
    chk("R11", "next after srst", nxt, 32'h0);
    rd(8'h00, r);
    chk("R11", "ctrl read after srst", r, 32'h4000_0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule